// File: doc/BRIEF.md
# Ping-Pong Pixel Buffer Controller

This block sits in a blitter data path between a pixel producer and a pixel consumer. Its storage is split into two equal halves. The producer fills one half while the consumer empties the other. Each half has a ready flag. A half becomes ready when it holds a full half of pixels. It also becomes ready when the job's programmed pixel total runs out part way through the half, so the final remainder still reaches the consumer.

A job starts with a one-cycle start pulse. The pulse carries the total pixel count and a mode bit. In direct mode, a half's flag drops as soon as the consumer takes its last pixel. In output mode, the flag stays up until a downstream transfer-complete pulse confirms that the half's contents have left the block.

The status word holds both half flags and a source-done flag. The source-done flag is high once every source pixel of the job has been accepted while some half is still waiting on the destination side. It is low when the block is idle and once the job has finished.

Top module: `pixbuf_pingpong`

## Requirements
- R1: After reset, status_o is 3'b000, wr_ready_o is 0 and rd_valid_o is 0.
- R2: status_o[0] is the ready flag of half 1 and status_o[1] is the ready flag of half 2. A half's flag rises in the cycle after the write that fills it with HALF_PIX pixels.
- R3: When the programmed count runs out part way through a half, that half's flag rises after the last write. The consumer sees rd_last_o on the last remainder pixel.
- R4: Halves are filled and drained alternately, starting with half 1. Pixels leave in the order they were written.
- R5: wr_ready_o is low while the next half to fill still has its flag set. It is also low once the job's count has been used up.
- R6: rd_last_o is high together with rd_valid_o on pixel HALF_PIX-1 of a full half, and on no earlier pixel of that half.
- R7: In direct mode (out_mode_i=0 at start), a half's flag clears in the cycle after the consumer accepts its rd_last_o pixel.
- R8: In output mode (out_mode_i=1 at start), a drained half keeps its flag set until xfer_done_i is pulsed. The flag clears in the cycle after that pulse.
- R9: status_o[2] is 1 when all pixels of the job have been written and at least one half flag is still set. It is 0 when the block is idle or the job has completed.
- R10: A start pulse while a job is active is ignored. The remaining count and the mode bit are unchanged.
- R11: A start with count 0 completes at once: no half flag rises, wr_ready_o stays 0 and status_o[2] stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for a job |
| count_i | input | CNT_W | Total pixels of the job, sampled on start |
| out_mode_i | input | 1 | 1 = flags clear on downstream completion, sampled on start |
| wr_valid_i | input | 1 | Producer pixel valid |
| wr_data_i | input | PIX_W | Producer pixel |
| wr_ready_o | output | 1 | Buffer can accept a pixel |
| rd_valid_o | output | 1 | Consumer pixel valid |
| rd_data_o | output | PIX_W | Consumer pixel |
| rd_ready_i | input | 1 | Consumer takes the pixel |
| rd_last_o | output | 1 | Last pixel of the current half |
| xfer_done_i | input | 1 | Downstream transfer of the oldest drained half completed |
| status_o | output | 3 | [0] half 1 ready, [1] half 2 ready, [2] source done |

## Verification
A half whose state is corrupted shows up at the status port within one cycle of the write or read that should have changed it. It can also show up as a producer that stalls, or fails to stall, at the next half boundary. A wrong write or read index appears on the consumer side as a pixel out of order, or as a misplaced rd_last_o, as soon as the affected half drains. A bad remaining count shows up after the final write: wr_ready_o is wrong, or the source-done flag is wrong. A start pulse that is not ignored during a job shows up in the same way.

// File: rtl/pb_pkg.sv
package pb_pkg;
    typedef enum logic [1:0] {
        H_EMPTY = 2'd0,
        H_READY = 2'd1,
        H_WAIT  = 2'd2
    } half_st_t;
endpackage

// File: rtl/pb_store.sv
module pb_store #(
    parameter int PIX_W = 16,
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [PIX_W-1:0] wdata_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [PIX_W-1:0] rdata_o
);
    logic [PIX_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pb_seq.sv
module pb_seq
    import pb_pkg::*;
#(
    parameter int HALF_PIX = 16,
    parameter int CNT_W    = 16,
    localparam int IDX_W   = $clog2(HALF_PIX),
    localparam int AW      = $clog2(2 * HALF_PIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             mode_i,
    input  logic             wr_valid_i,
    output logic             wr_ready_o,
    output logic             wr_en_o,
    output logic [AW-1:0]    wr_addr_o,
    output logic             rd_valid_o,
    input  logic             rd_ready_i,
    output logic             rd_last_o,
    output logic [AW-1:0]    rd_addr_o,
    input  logic             xfer_done_i,
    output logic [1:0]       half_rdy_o,
    output logic             src_done_o
);
    typedef struct packed {
        logic                       active;
        logic                       mode;
        logic [CNT_W-1:0]           remain;
        logic                       wr_half;
        logic [IDX_W-1:0]           wr_idx;
        logic                       rd_half;
        logic [IDX_W-1:0]           rd_idx;
        logic                       ack_half;
        half_st_t [1:0]             hst;
        logic [1:0][IDX_W-1:0]      last_idx;
    } seq_t;

    seq_t s_d, s_q;
    logic wr_go, rd_go;

    assign wr_ready_o = s_q.active && (s_q.remain != '0) && (s_q.hst[s_q.wr_half] == H_EMPTY);
    assign rd_valid_o = (s_q.hst[s_q.rd_half] == H_READY);
    assign rd_last_o  = rd_valid_o && (s_q.rd_idx == s_q.last_idx[s_q.rd_half]);
    assign wr_go      = wr_valid_i && wr_ready_o;
    assign rd_go      = rd_valid_o && rd_ready_i;
    assign wr_en_o    = wr_go;
    assign wr_addr_o  = AW'(s_q.wr_half) * AW'(HALF_PIX) + AW'(s_q.wr_idx);
    assign rd_addr_o  = AW'(s_q.rd_half) * AW'(HALF_PIX) + AW'(s_q.rd_idx);
    assign src_done_o = s_q.active && (s_q.remain == '0);

    generate
        for (genvar h = 0; h < 2; h++) begin : g_flag
            assign half_rdy_o[h] = (s_q.hst[h] != H_EMPTY);
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        if (!s_q.active && start_i && (count_i != '0)) begin
            s_d.active   = 1'b1;
            s_d.mode     = mode_i;
            s_d.remain   = count_i;
            s_d.wr_half  = 1'b0;
            s_d.wr_idx   = '0;
            s_d.rd_half  = 1'b0;
            s_d.rd_idx   = '0;
            s_d.ack_half = 1'b0;
        end
        if (wr_go) begin
            s_d.remain = s_q.remain - CNT_W'(1);
            if ((s_q.wr_idx == IDX_W'(HALF_PIX - 1)) || (s_q.remain == CNT_W'(1))) begin
                s_d.hst[s_q.wr_half]      = H_READY;
                s_d.last_idx[s_q.wr_half] = s_q.wr_idx;
                s_d.wr_half               = ~s_q.wr_half;
                s_d.wr_idx                = '0;
            end else begin
                s_d.wr_idx = s_q.wr_idx + IDX_W'(1);
            end
        end
        if (rd_go) begin
            if (rd_last_o) begin
                s_d.hst[s_q.rd_half] = s_q.mode ? H_WAIT : H_EMPTY;
                s_d.rd_half          = ~s_q.rd_half;
                s_d.rd_idx           = '0;
            end else begin
                s_d.rd_idx = s_q.rd_idx + IDX_W'(1);
            end
        end
        if (xfer_done_i && (s_q.hst[s_q.ack_half] == H_WAIT)) begin
            s_d.hst[s_q.ack_half] = H_EMPTY;
            s_d.ack_half          = ~s_q.ack_half;
        end
        if (s_q.active && (s_d.remain == '0) &&
            (s_d.hst[0] == H_EMPTY) && (s_d.hst[1] == H_EMPTY)) begin
            s_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (half_rdy_o == 2'b00 && !src_done_o && !wr_ready_o && !rd_valid_o));

    p_no_overfill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready_o |-> !half_rdy_o[s_q.wr_half]);

    p_flag_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        src_done_o |-> (half_rdy_o != 2'b00));

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && start_i && !wr_go) |=> (s_q.remain == $past(s_q.remain) && s_q.mode == $past(s_q.mode)));

    generate
        for (genvar h = 0; h < 2; h++) begin : g_chk
            p_last_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_go && rd_last_o && s_q.rd_half == 1'(h) && !s_q.mode) |=> !half_rdy_o[h]);
            p_wait_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (s_q.hst[h] == H_WAIT && !(xfer_done_i && s_q.ack_half == 1'(h))) |=> half_rdy_o[h]);
        end
    endgenerate
endmodule

// File: rtl/pixbuf_pingpong.sv
module pixbuf_pingpong #(
    parameter int PIX_W    = 16,
    parameter int HALF_PIX = 16,
    parameter int CNT_W    = 16,
    localparam int AW      = $clog2(2 * HALF_PIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             out_mode_i,
    input  logic             wr_valid_i,
    input  logic [PIX_W-1:0] wr_data_i,
    output logic             wr_ready_o,
    output logic             rd_valid_o,
    output logic [PIX_W-1:0] rd_data_o,
    input  logic             rd_ready_i,
    output logic             rd_last_o,
    input  logic             xfer_done_i,
    output logic [2:0]       status_o
);
    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [1:0]    half_rdy;
    logic          src_done;

    pb_seq #(.HALF_PIX(HALF_PIX), .CNT_W(CNT_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .count_i    (count_i),
        .mode_i     (out_mode_i),
        .wr_valid_i (wr_valid_i),
        .wr_ready_o (wr_ready_o),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .rd_valid_o (rd_valid_o),
        .rd_ready_i (rd_ready_i),
        .rd_last_o  (rd_last_o),
        .rd_addr_o  (rd_addr),
        .xfer_done_i(xfer_done_i),
        .half_rdy_o (half_rdy),
        .src_done_o (src_done)
    );

    pb_store #(.PIX_W(PIX_W), .DEPTH(2 * HALF_PIX)) i_store (
        .clk    (clk),
        .we_i   (wr_en),
        .waddr_i(wr_addr),
        .wdata_i(wr_data_i),
        .raddr_i(rd_addr),
        .rdata_o(rd_data_o)
    );

    assign status_o = {src_done, half_rdy};

    p_read_only_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (half_rdy != 2'b00));
endmodule

// File: tb/test_pixbuf_pingpong.sv
module test_pixbuf_pingpong;
    localparam int PIX_W = 16;
    localparam int HALF  = 16;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] count_i = '0;
    logic             out_mode_i = 1'b0;
    logic             wr_valid_i = 1'b0;
    logic [PIX_W-1:0] wr_data_i = '0;
    logic             wr_ready_o;
    logic             rd_valid_o;
    logic [PIX_W-1:0] rd_data_o;
    logic             rd_ready_i = 1'b0;
    logic             rd_last_o;
    logic             xfer_done_i = 1'b0;
    logic [2:0]       status_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pixbuf_pingpong #(.PIX_W(PIX_W), .HALF_PIX(HALF), .CNT_W(CNT_W)) i_pixbuf_pingpong (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
        .out_mode_i(out_mode_i), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
        .wr_ready_o(wr_ready_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
        .rd_ready_i(rd_ready_i), .rd_last_o(rd_last_o), .xfer_done_i(xfer_done_i),
        .status_o(status_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic start_job(input int cnt, input bit mode);
        @(negedge clk);
        start_i = 1'b1; count_i = CNT_W'(cnt); out_mode_i = mode;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic push_px(input int d);
        @(negedge clk);
        wr_valid_i = 1'b1; wr_data_i = PIX_W'(d);
        while (!wr_ready_o) @(negedge clk);
        @(posedge clk); #1;
        wr_valid_i = 1'b0;
    endtask

    task automatic pop_px(input int d, input bit last, input string tag);
        @(negedge clk);
        rd_ready_i = 1'b1;
        while (!rd_valid_o) @(negedge clk);
        check(rd_data_o == PIX_W'(d), {tag, " data"}, int'(rd_data_o), d);
        check(rd_last_o == last, {tag, " last"}, int'(rd_last_o), int'(last));
        @(posedge clk); #1;
        rd_ready_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(status_o == 3'b000, "R1 status", int'(status_o), 0);
        check(!wr_ready_o, "R1 wr_ready", int'(wr_ready_o), 0);
        check(!rd_valid_o, "R1 rd_valid", int'(rd_valid_o), 0);
    endtask

    task automatic t_full_halves();
        start_job(2 * HALF, 1'b0);
        for (int i = 0; i < HALF; i++) push_px(100 + i);
        check(status_o == 3'b001, "R2 half1 flag", int'(status_o), 1);
        check(wr_ready_o, "R4 half2 open", int'(wr_ready_o), 1);
        for (int i = HALF; i < 2 * HALF; i++) push_px(100 + i);
        check(status_o == 3'b111, "R2 R9 both flags", int'(status_o), 7);
        check(!wr_ready_o, "R5 stall", int'(wr_ready_o), 0);
        for (int i = 0; i < HALF; i++) pop_px(100 + i, i == HALF - 1, "R4 R6 half1");
        check(status_o == 3'b110, "R7 half1 cleared", int'(status_o), 6);
        for (int i = HALF; i < 2 * HALF; i++) pop_px(100 + i, i == 2 * HALF - 1, "R4 R6 half2");
        check(status_o == 3'b000, "R9 done", int'(status_o), 0);
    endtask

    task automatic t_partial();
        start_job(HALF + 5, 1'b0);
        for (int i = 0; i < HALF + 5; i++) push_px(300 + i);
        check(status_o == 3'b111, "R3 remainder flag", int'(status_o), 7);
        for (int i = 0; i < HALF + 5; i++)
            pop_px(300 + i, (i == HALF - 1) || (i == HALF + 4), "R3 remainder");
        check(status_o == 3'b000, "R3 end", int'(status_o), 0);
    endtask

    task automatic t_restart();
        start_job(3, 1'b0);
        push_px(500);
        start_job(40, 1'b1);
        push_px(501);
        push_px(502);
        check(!wr_ready_o, "R10 count kept", int'(wr_ready_o), 0);
        check(status_o == 3'b101, "R10 status", int'(status_o), 5);
        pop_px(500, 1'b0, "R10");
        pop_px(501, 1'b0, "R10");
        pop_px(502, 1'b1, "R10");
        check(status_o == 3'b000, "R10 mode kept", int'(status_o), 0);
    endtask

    task automatic t_zero();
        start_job(0, 1'b0);
        repeat (2) @(negedge clk);
        check(status_o == 3'b000, "R11 status", int'(status_o), 0);
        check(!wr_ready_o, "R11 wr_ready", int'(wr_ready_o), 0);
        start_job(2, 1'b0);
        check(wr_ready_o, "R11 next job", int'(wr_ready_o), 1);
        push_px(600); push_px(601);
        pop_px(600, 1'b0, "R11"); pop_px(601, 1'b1, "R11");
    endtask

    task automatic t_out_mode();
        start_job(HALF, 1'b1);
        for (int i = 0; i < HALF; i++) push_px(700 + i);
        for (int i = 0; i < HALF; i++) pop_px(700 + i, i == HALF - 1, "R8 drain");
        repeat (3) @(negedge clk);
        check(status_o == 3'b101, "R8 held", int'(status_o), 5);
        @(negedge clk); xfer_done_i = 1'b1;
        @(posedge clk); #1 xfer_done_i = 1'b0;
        check(status_o == 3'b000, "R8 cleared", int'(status_o), 0);
    endtask

    task automatic t_stream();
        start_job(50, 1'b0);
        fork
            for (int i = 0; i < 50; i++) push_px(900 + i);
            for (int i = 0; i < 50; i++) begin
                if (i % 3 == 0) repeat (2) @(negedge clk);
                pop_px(900 + i, (i % HALF == HALF - 1) || (i == 49), "R4 R5 stream");
            end
        join
        @(negedge clk);
        check(status_o == 3'b000, "R9 stream done", int'(status_o), 0);
    endtask

    initial begin
        t_reset();
        t_full_halves();
        t_partial();
        t_restart();
        t_zero();
        t_out_mode();
        t_stream();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule